// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block is the slave side of a microcontroller bus on which address and data share the same eight wires. The host puts an address on the bus while it holds the latch strobe high. It then pulses an active-low write strobe with data on the bus, or holds an active-low read strobe low to fetch a byte. Every bus pin is sampled by the system clock. The block turns each write strobe into a single one-cycle enable pulse for the decoded destination. The write word carries nine bits: the eight bus bits, with bit 7 of the latched address placed on top as bit 8.

Destinations sit at consecutive addresses starting at `DEST_BASE`. The eight lowest addresses, 0x00 to 0x07, are broadcast columns. A write there reaches every destination whose index modulo 8 equals the column number, so one strobe can load several registers with the same value. Reads pick one of seven byte-wide sources at addresses starting at `RD_BASE`. The seventh source is a status byte. The register file uses it to report bit 8 of its nine-bit registers, since the bus carries only eight bits. The bus output enable is asserted only while a read of a readable address is in progress. The register contents behind each destination live outside this block.

Top module: `muxbus_regif`

## Requirements
- R1: After reset, `wrEn` is all zero, `wrData` is 0x000, `busOe` is 0 and `busOut` is 0x00.
- R2: The address is captured from `busIn` while `ale` is high and is held while `ale` is low. Data placed on the bus after `ale` falls does not change the decoded destination.
- R3: Each falling edge of `wrN` produces exactly one write pulse, no matter how long `wrN` stays low. The decoded `wrEn` bits are high for one clock cycle, starting at the second rising edge after the first edge at which `wrN` is sampled low.
- R4: Decoding uses the low 7 bits of the latched address. The value `DEST_BASE + d` (default `DEST_BASE` = 0x08), for d from 0 to NUM_DEST-1 (default 40), sets only `wrEn[d]`. Address bit 7 does not affect decoding.
- R5: `wrData[7:0]` equals the bus byte present at the write strobe. `wrData[8]` equals bit 7 of the latched address when at least one enabled destination is nine bits wide.
- R6: `wrData[8]` is 0 when none of the enabled destinations is nine bits wide. Destination d is nine bits wide when `WIDE_MASK[d]` is 1; by default only destinations 0 to 7 are.
- R7: A write whose latched low 7 address bits hold a value c from 0 to 7 sets `wrEn[d]` for every d with d mod 8 == c, and no other bit. With the default 40 destinations, that is five bits.
- R8: A write to a low-7-bit address that maps to no destination, such as 0x30 with the defaults, leaves every `wrEn` bit at 0.
- R9: A read of low-7-bit address `RD_BASE + s` (default `RD_BASE` = 0x70), for s from 0 to 5, drives byte s of `srcWord` (bits 8s+7 down to 8s) on `busOut`. `busOe` is high from the second rising edge after `rdN` is sampled low. It falls at the second rising edge after `rdN` is sampled high.
- R10: A read of `RD_BASE + 6` (default 0x76) drives `statusBits`, the status byte that carries bit 8 of the nine-bit registers.
- R11: When `rdN` is high, or the latched address is not a readable source, `busOe` is 0 and `busOut` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch enable, active high |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| busIn | input | 8 | Multiplexed address/data bus, input side |
| busOut | output | 8 | Read data for the bus, input to the external bus driver |
| busOe | output | 1 | Bus driver enable; high drives `busOut`, low leaves the bus high impedance |
| srcWord | input | 48 | Six byte-wide read sources, source s in bits 8s+7 down to 8s |
| statusBits | input | 8 | Status source that carries bit 8 of the nine-bit registers |
| wrEn | output | 40 | One-cycle write enable per destination |
| wrData | output | 9 | Merged nine-bit write word |

## Verification
The hardest situations to reach are the ones that depend on the order of events on the bus. One is a long write strobe, which must still give only one pulse. Another is bus traffic after the latch strobe has fallen, which must not move the address. A third is a broadcast column that mixes nine-bit and eight-bit destinations, which decides how bit 8 of the write word is formed. The stimulus reaches these by holding the write strobe low for several cycles and checking that the enables stay quiet after the first pulse. It also changes the bus between the latch phase and the write phase, and it writes broadcast columns with address bit 7 both set and clear.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  localparam int BUS_W = 8;

  // Strobes passed from the bus control to the datapath, one clock each.
  typedef struct packed {
    logic latchAddr;   // capture the sampled bus as the address
    logic writeGo;     // single write pulse for this strobe access
    logic readOn;      // read strobe is currently held low
  } ctrlStrobe_t;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ale,
  input  logic             wrN,
  input  logic             rdN,
  input  logic [BUS_W-1:0] busIn,
  output ctrlStrobe_t      strb,
  output logic [BUS_W-1:0] busS
);

  logic aleS;
  logic wrS;
  logic wrPrev;
  logic rdS;

  // Sample every bus pin once on the system clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleS   <= 1'b0;
      wrS    <= 1'b1;
      wrPrev <= 1'b1;
      rdS    <= 1'b1;
      busS   <= '0;
    end else begin
      aleS   <= ale;
      wrS    <= wrN;
      wrPrev <= wrS;
      rdS    <= rdN;
      busS   <= busIn;
    end
  end

  always_comb begin
    strb.latchAddr = aleS;
    strb.writeGo   = wrPrev & ~wrS;
    strb.readOn    = ~rdS;
  end

  // A write strobe access never yields two pulses back to back.
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeGo |=> !strb.writeGo);

endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath
  import muxbus_pkg::*;
#(
  parameter int                 NUM_DEST   = 40,
  parameter int                 BCAST_COLS = 8,
  parameter int                 DEST_BASE  = 8,
  parameter int                 RD_BASE    = 'h70,
  parameter int                 NUM_SRC    = 7,
  parameter logic [NUM_DEST-1:0] WIDE_MASK = NUM_DEST'(8'hFF)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strb,
  input  logic [BUS_W-1:0]               busS,
  input  logic [(NUM_SRC-1)*BUS_W-1:0]   srcWord,
  input  logic [BUS_W-1:0]               statusBits,
  output logic [NUM_DEST-1:0]            wrEn,
  output logic [BUS_W:0]                 wrData,
  output logic                           busOe,
  output logic [BUS_W-1:0]               busOut
);

  localparam int COL_DEPTH = (NUM_DEST + BCAST_COLS - 1) / BCAST_COLS;
  localparam int ADDR_LO_W = BUS_W - 1;

  logic [BUS_W-1:0]     addrQ;
  logic [ADDR_LO_W-1:0] addrLo;
  logic [NUM_DEST-1:0]  decEn;
  logic                 isBcast;
  logic                 hiBit;
  logic                 readable;
  logic [BUS_W-1:0]     muxOut;

  assign addrLo  = addrQ[ADDR_LO_W-1:0];
  assign isBcast = addrLo < ADDR_LO_W'(BCAST_COLS);

  // Per-destination decode: own address, or membership of a broadcast column.
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dec
    assign decEn[d] = (addrLo == ADDR_LO_W'(DEST_BASE + d)) ||
                      (isBcast && (addrLo == ADDR_LO_W'(d % BCAST_COLS)));
  end

  // Bit 8 only survives when some targeted register is nine bits wide.
  assign hiBit = addrQ[BUS_W-1] & (|(decEn & WIDE_MASK));

  assign readable = (addrLo >= ADDR_LO_W'(RD_BASE)) &&
                    (addrLo <  ADDR_LO_W'(RD_BASE + NUM_SRC));

  always_comb begin
    muxOut = '0;
    for (int s = 0; s < NUM_SRC - 1; s++) begin
      if (addrLo == ADDR_LO_W'(RD_BASE + s)) muxOut = srcWord[s*BUS_W +: BUS_W];
    end
    if (addrLo == ADDR_LO_W'(RD_BASE + NUM_SRC - 1)) muxOut = statusBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wrEn   <= '0;
      wrData <= '0;
      busOe  <= 1'b0;
      busOut <= '0;
    end else begin
      if (strb.latchAddr) addrQ <= busS;
      if (strb.writeGo) begin
        wrEn   <= decEn;
        wrData <= {hiBit, busS};
      end else begin
        wrEn   <= '0;
      end
      busOe  <= strb.readOn & readable;
      busOut <= (strb.readOn & readable) ? muxOut : '0;
    end
  end

  p_one_cycle_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|wrEn) |=> !(|wrEn));

  p_col_depth_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrEn) <= COL_DEPTH);

  p_narrow_bit8_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((|wrEn) && ((wrEn & WIDE_MASK) == '0)) |-> !wrData[BUS_W]);

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busOut == '0));

endmodule

// File: rtl/muxbus_regif.sv
module muxbus_regif
  import muxbus_pkg::*;
#(
  parameter int                 NUM_DEST   = 40,
  parameter int                 BCAST_COLS = 8,
  parameter int                 DEST_BASE  = 8,
  parameter int                 RD_BASE    = 'h70,
  parameter int                 NUM_SRC    = 7,
  parameter logic [NUM_DEST-1:0] WIDE_MASK = NUM_DEST'(8'hFF)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ale,
  input  logic                         wrN,
  input  logic                         rdN,
  input  logic [BUS_W-1:0]             busIn,
  output logic [BUS_W-1:0]             busOut,
  output logic                         busOe,
  input  logic [(NUM_SRC-1)*BUS_W-1:0] srcWord,
  input  logic [BUS_W-1:0]             statusBits,
  output logic [NUM_DEST-1:0]          wrEn,
  output logic [BUS_W:0]               wrData
);

  ctrlStrobe_t      strb;
  logic [BUS_W-1:0] busS;

  muxbus_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ale   (ale),
    .wrN   (wrN),
    .rdN   (rdN),
    .busIn (busIn),
    .strb  (strb),
    .busS  (busS)
  );

  muxbus_dpath #(
    .NUM_DEST   (NUM_DEST),
    .BCAST_COLS (BCAST_COLS),
    .DEST_BASE  (DEST_BASE),
    .RD_BASE    (RD_BASE),
    .NUM_SRC    (NUM_SRC),
    .WIDE_MASK  (WIDE_MASK)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busS       (busS),
    .srcWord    (srcWord),
    .statusBits (statusBits),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .busOe      (busOe),
    .busOut     (busOut)
  );

endmodule

// File: tb/muxbus_regif_bench.sv
module muxbus_regif_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ale = 1'b0;
  logic        wrN = 1'b1;
  logic        rdN = 1'b1;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [47:0] srcWord = 48'h665544332211;
  logic [7:0]  statusBits = 8'hC3;
  logic [39:0] wrEn;
  logic [8:0]  wrData;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;   // 125 MHz

  muxbus_regif u_muxbus_regif (
    .clk(clk), .rstN(rstN), .ale(ale), .wrN(wrN), .rdN(rdN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .srcWord(srcWord), .statusBits(statusBits),
    .wrEn(wrEn), .wrData(wrData)
  );

  // {addr, data, expected enables, expected nine-bit word}
  localparam logic [64:0] VEC [8] = '{
    {8'h08, 8'h5A, 40'h00_0000_0001, 9'h05A},  // R4 R5 single wide
    {8'h88, 8'hA5, 40'h00_0000_0001, 9'h1A5},  // R5 bit 7 becomes bit 8
    {8'h90, 8'h3C, 40'h00_0000_0100, 9'h03C},  // R6 narrow drops bit 8
    {8'h2F, 8'hFF, 40'h80_0000_0000, 9'h0FF},  // R4 last destination
    {8'h03, 8'h11, 40'h08_0808_0808, 9'h011},  // R7 column 3
    {8'h85, 8'h22, 40'h20_2020_2020, 9'h122},  // R7 column 5 with bit 8
    {8'hB0, 8'h77, 40'h00_0000_0000, 9'h077},  // R8 unused address
    {8'h87, 8'h80, 40'h80_8080_8080, 9'h180}   // R7 column 7 with bit 8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic latchAddr(input logic [7:0] a);
    @(negedge clk); ale = 1'b1; busIn = a;
    @(negedge clk);
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Drives a write; samples the pulse cycle and the cycle after.
  task automatic doWrite(input logic [7:0] d, input int holdCycles,
                         output logic [39:0] en, output logic [8:0] wd,
                         output logic [39:0] enAfter);
    busIn = d; wrN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    en = wrEn; wd = wrData;
    @(negedge clk);
    enAfter = wrEn;
    repeat (holdCycles) begin
      @(negedge clk);
      enAfter = enAfter | wrEn;
    end
    wrN = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic doRead(output logic oe, output logic [7:0] q, output logic oeAfter);
    rdN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    oe = busOe; q = busOut;
    rdN = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    oeAfter = busOe;
  endtask

  initial begin
    logic [39:0] en, enAfter;
    logic [8:0]  wd;
    logic        oe, oeAfter;
    logic [7:0]  q;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wrEn", 64'(wrEn), 64'h0);
    chk("R1 wrData", 64'(wrData), 64'h0);
    chk("R1 busOe", 64'(busOe), 64'h0);
    chk("R1 busOut", 64'(busOut), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      latchAddr(VEC[i][64:57]);
      doWrite(VEC[i][56:49], 0, en, wd, enAfter);
      chk($sformatf("R4 R7 R8 vec%0d enables", i), 64'(en), 64'(VEC[i][48:9]));
      chk($sformatf("R5 R6 vec%0d data", i), 64'(wd), 64'(VEC[i][8:0]));
      chk($sformatf("R3 vec%0d pulse ends", i), 64'(enAfter), 64'h0);
    end

    // R3 long strobe gives one pulse only
    latchAddr(8'h0A);
    doWrite(8'h44, 6, en, wd, enAfter);
    chk("R3 long strobe pulse", 64'(en), 64'h4);
    chk("R3 long strobe no repeat", 64'(enAfter), 64'h0);

    // R2 bus traffic after ale falls keeps the address
    latchAddr(8'h09);
    busIn = 8'h0C; @(negedge clk); busIn = 8'h2F; @(negedge clk); @(negedge clk);
    doWrite(8'h33, 0, en, wd, enAfter);
    chk("R2 address held", 64'(en), 64'h2);
    chk("R2 data from write phase", 64'(wd), 64'h033);

    // R9 regular sources
    for (int s = 0; s < 6; s++) begin
      latchAddr(8'(8'h70 + s));
      doRead(oe, q, oeAfter);
      chk($sformatf("R9 src%0d oe", s), 64'(oe), 64'h1);
      chk($sformatf("R9 src%0d data", s), 64'(q), 64'(8'(8'h11 * (s + 1))));
      chk($sformatf("R9 src%0d oe released", s), 64'(oeAfter), 64'h0);
    end

    // R10 status source, address bit 7 set
    latchAddr(8'hF6);
    doRead(oe, q, oeAfter);
    chk("R10 status oe", 64'(oe), 64'h1);
    chk("R10 status data", 64'(q), 64'hC3);

    // R11 unreadable addresses and idle strobe
    latchAddr(8'h77);
    doRead(oe, q, oeAfter);
    chk("R11 addr 0x77 oe", 64'(oe), 64'h0);
    chk("R11 addr 0x77 data", 64'(q), 64'h0);
    latchAddr(8'h08);
    doRead(oe, q, oeAfter);
    chk("R11 addr 0x08 oe", 64'(oe), 64'h0);
    latchAddr(8'h71);
    repeat (3) @(negedge clk);
    chk("R11 idle oe", 64'(busOe), 64'h0);
    chk("R11 idle data", 64'(busOut), 64'h0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule